// File: doc/BRIEF.md
# Timer-Driven Serial Baud Tick Generator

This block produces the two timing strobes an asynchronous serial port needs: a sixteen-times oversampling strobe for the receive sampler and a bit-rate strobe for the shifters. All logic runs on one fast clock `clk`. The oscillator and the system clock are given as single-cycle enable pulses on that clock, so a clock multiplier in front of the block appears only as a denser `sys_en` pattern.

In timer mode an 8-bit up-counter advances once per timer input pulse and reloads from `reload` when it wraps. There are three choices for the timer input pulse: every twelfth oscillator enable, every fourth system enable, or every system enable. The high-speed select wins over the divide-by-four select. Each wrap raises `ovf_tick`. The doubling bit `dbl` chooses whether every wrap or every second wrap becomes an oversampling strobe. Every sixteenth oversampling strobe becomes a bit strobe. The resulting rate is 2^dbl × f_in / (32 × (256 − reload)). In fixed mode the timer is bypassed. The oversampling strobe then comes straight from the oscillator enables, so the bit rate is the oscillator rate over 64, or over 32 with `dbl` set.

The block carries no data stream. Every input is a level or a strobe that is sampled on each clock, so no valid/ready handshake applies and nothing is ever back-pressured. The consumer must act on each output strobe in the cycle it is high.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `ovf_tick`, `os_tick` and `bit_tick` are 0 and the timer count is 0.
- R2: The timer input is selected by `hs_sel`/`q4_sel`. With both 0 it is every 12th `osc_en`. With only `q4_sel` = 1 it is every 4th `sys_en`. With `hs_sel` = 1 it is every `sys_en`.
- R3: With `hs_sel` = 1, the value of `q4_sel` has no effect on any rate.
- R4: The timer counts input pulses up to FFh and then loads `reload`, so successive `ovf_tick` pulses are 256 − `reload` timer input pulses apart. Each `ovf_tick` lasts one cycle and only ever follows a cycle with `run` = 1.
- R5: In timer mode `os_tick` follows every `ovf_tick` by one cycle when `dbl` = 1, and follows every second `ovf_tick` when `dbl` = 0.
- R6: `bit_tick` pulses one cycle after every 16th `os_tick`.
- R7: With `fixed_mode` = 1, `os_tick` occurs once per 2 `osc_en` pulses (`dbl` = 1) or once per 4 (`dbl` = 0), whatever `run`, `reload` and the speed selects are. This gives a bit strobe at the oscillator rate over 32 or over 64.
- R8: While `run` = 0 the timer count holds and the prescalers clear. In timer mode the strobes stop within three cycles. After `run` returns to 1, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| sys_en | input | 1 | One-cycle pulse per system clock period |
| hs_sel | input | 1 | Timer input is the undivided system clock |
| q4_sel | input | 1 | Timer input is the system clock over 4 (when `hs_sel` = 0) |
| dbl | input | 1 | Rate doubling bit |
| fixed_mode | input | 1 | Use the fixed oscillator path instead of the timer |
| run | input | 1 | Timer run enable |
| reload | input | 8 | Timer reload value |
| ovf_tick | output | 1 | Timer wrap strobe |
| os_tick | output | 1 | Sixteen-times oversampling strobe |
| bit_tick | output | 1 | Bit-rate strobe |

## Verification
The assertions check several rules on every clock. The count never moves in a cycle after `run` was low. No wrap strobe appears without `run`. Each bit strobe is preceded by an oversampling strobe. In timer mode each oversampling strobe is preceded by a wrap strobe. The actual division ratios can only be shown by the bench's scenarios, which measure the spacing between bit strobes in cycles. These ratios are the twelve/four/one prescale, the high-speed override, 256 − reload, the doubling and the fixed over-32/over-64 path. The same applies to the wrap spacing and to the resume count after a pause.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  typedef enum logic [1:0] {
    TIN_OSC_SLOW = 2'd0,
    TIN_SYS_QTR  = 2'd1,
    TIN_SYS_FULL = 2'd2
  } tin_src_e;

  // high-speed select has priority over the quarter-rate select
  function automatic tin_src_e pick_src(input logic hs, input logic q4);
    if (hs)      return TIN_SYS_FULL;
    else if (q4) return TIN_SYS_QTR;
    else         return TIN_OSC_SLOW;
  endfunction
endpackage

// File: rtl/bg_prescale.sv
module bg_prescale
  import baudgen_pkg::*;
#(
  parameter int OSC_DIV = 12,
  parameter int SYS_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic osc_en,
  input  logic sys_en,
  input  logic hs_sel,
  input  logic q4_sel,
  output logic tin
);
  localparam int OW = $clog2(OSC_DIV);
  localparam int SW = $clog2(SYS_DIV);
  localparam logic [OW-1:0] OLAST = OW'(OSC_DIV - 1);
  localparam logic [SW-1:0] SLAST = SW'(SYS_DIV - 1);

  logic [OW-1:0] osc_cnt;
  logic [SW-1:0] sys_cnt;
  logic osc_hit, sys_hit;
  tin_src_e src;

  assign osc_hit = run && osc_en && (osc_cnt == OLAST);
  assign sys_hit = run && sys_en && (sys_cnt == SLAST);
  assign src     = pick_src(hs_sel, q4_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_cnt <= '0;
      sys_cnt <= '0;
    end else if (!run) begin
      osc_cnt <= '0;
      sys_cnt <= '0;
    end else begin
      if (osc_en) osc_cnt <= (osc_cnt == OLAST) ? '0 : osc_cnt + 1'b1;
      if (sys_en) sys_cnt <= (sys_cnt == SLAST) ? '0 : sys_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (src)
      TIN_SYS_FULL: tin = run && sys_en;
      TIN_SYS_QTR:  tin = sys_hit;
      default:      tin = osc_hit;
    endcase
  end
endmodule

// File: rtl/bg_reload_timer.sv
module bg_reload_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tin,
  input  logic [CW-1:0] reload,
  output logic          ovf,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (run && tin) begin
      if (cnt == TOP) begin
        cnt <= reload;
        ovf <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        ovf <= 1'b0;
      end
    end else begin
      ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/bg_tick_div.sv
module bg_tick_div #(
  parameter int OS_PER_BIT = 16,
  parameter int FIX_FAST   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic osc_en,
  input  logic dbl,
  input  logic fixed_mode,
  output logic os_tick,
  output logic bit_tick
);
  localparam int FIX_SLOW = 2 * FIX_FAST;
  localparam int FW = $clog2(FIX_SLOW);
  localparam int BW = $clog2(OS_PER_BIT);
  localparam logic [BW-1:0] BLAST = BW'(OS_PER_BIT - 1);

  logic          half;
  logic          ovf_pass;
  logic [FW-1:0] fcnt;
  logic [FW-1:0] flast;
  logic          fix_hit;
  logic [BW-1:0] bcnt;

  assign ovf_pass = ovf && (dbl || half);
  assign flast    = dbl ? FW'(FIX_FAST - 1) : FW'(FIX_SLOW - 1);
  assign fix_hit  = osc_en && (fcnt >= flast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half     <= 1'b0;
      fcnt     <= '0;
      bcnt     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      if (ovf) half <= ~half;
      if (osc_en) fcnt <= (fcnt >= flast) ? '0 : fcnt + 1'b1;
      os_tick  <= fixed_mode ? fix_hit : ovf_pass;
      bit_tick <= 1'b0;
      if (os_tick) begin
        if (bcnt == BLAST) begin
          bcnt     <= '0;
          bit_tick <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CW         = 8,
  parameter int OSC_DIV    = 12,
  parameter int SYS_DIV    = 4,
  parameter int OS_PER_BIT = 16,
  parameter int FIX_FAST   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          sys_en,
  input  logic          hs_sel,
  input  logic          q4_sel,
  input  logic          dbl,
  input  logic          fixed_mode,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          ovf_tick,
  output logic          os_tick,
  output logic          bit_tick
);
  logic          tin_w;
  logic [CW-1:0] cnt_w;

  bg_prescale #(.OSC_DIV(OSC_DIV), .SYS_DIV(SYS_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .osc_en(osc_en), .sys_en(sys_en),
    .hs_sel(hs_sel), .q4_sel(q4_sel), .tin(tin_w)
  );

  bg_reload_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .tin(tin_w), .reload(reload),
    .ovf(ovf_tick), .cnt(cnt_w)
  );

  bg_tick_div #(.OS_PER_BIT(OS_PER_BIT), .FIX_FAST(FIX_FAST)) u_div (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_tick), .osc_en(osc_en), .dbl(dbl),
    .fixed_mode(fixed_mode), .os_tick(os_tick), .bit_tick(bit_tick)
  );
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          fixed_mode,
  input logic          ovf_tick,
  input logic          os_tick,
  input logic          bit_tick,
  input logic [CW-1:0] timer_cnt
);
  // R8: a cleared run bit freezes the count
  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> timer_cnt == $past(timer_cnt));

  // R4: a wrap strobe only follows a running cycle
  a_r4_ovf_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_tick |-> $past(run));

  // R6: every bit strobe is preceded by an oversampling strobe
  a_r6_bit_after_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(os_tick));

  // R5: in timer mode an oversampling strobe is preceded by a wrap
  a_r5_os_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !$past(fixed_mode)) |-> $past(ovf_tick));
endmodule

bind baud_tick_gen bg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fixed_mode(fixed_mode),
  .ovf_tick(ovf_tick), .os_tick(os_tick), .bit_tick(bit_tick),
  .timer_cnt(cnt_w)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0, sys_en = 1'b1;
  logic hs_sel = 1'b0, q4_sel = 1'b0, dbl = 1'b0, fixed_mode = 1'b0, run = 1'b0;
  logic [7:0] reload = 8'h00;
  logic ovf_tick, os_tick, bit_tick;

  int checks = 0, errors = 0;
  longint cyc = 0;
  longint last_bit = 0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sys_en(sys_en),
    .hs_sel(hs_sel), .q4_sel(q4_sel), .dbl(dbl), .fixed_mode(fixed_mode),
    .run(run), .reload(reload), .ovf_tick(ovf_tick), .os_tick(os_tick),
    .bit_tick(bit_tick)
  );

  // oscillator enable: one pulse every second clock
  initial forever begin
    @(negedge clk);
    osc_en = rst_n ? ~osc_en : 1'b0;
  end

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: compare bit-strobe spacing against the scoreboard
  initial forever begin
    @(negedge clk);
    if (bit_tick) begin
      if (exp_q.size() > 0) begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, cyc - last_bit, e);
      end
      last_bit = cyc;
    end
  end

  task automatic wait_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!bit_tick) @(negedge clk);
    end
  endtask

  // driver: apply a setting, let it settle, queue expected periods
  task automatic expect_period(input string tag, input int per, input int n);
    wait_bits(3);
    #1;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(per);
      tag_q.push_back(tag);
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic setup(input logic h, input logic q, input logic d,
                       input logic f, input logic r, input logic [7:0] rl);
    @(negedge clk);
    hs_sel = h; q4_sel = q; dbl = d; fixed_mode = f; run = r; reload = rl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ovf", ovf_tick, 0);
    check("R1 os", os_tick, 0);
    check("R1 bit", bit_tick, 0);
    rst_n = 1'b1;

    // R2/R4/R5/R6: full-speed system input, reload FFh, doubled
    setup(1, 0, 1, 0, 1, 8'hFF);
    expect_period("R2 R4 R6 sys1 FFh dbl", 16, 3);
    // R4: reload F5h -> 11 counts per wrap
    setup(1, 0, 1, 0, 1, 8'hF5);
    expect_period("R4 sys1 F5h dbl", 176, 3);
    begin
      longint t0;
      @(negedge clk); while (!ovf_tick) @(negedge clk);
      t0 = cyc;
      @(negedge clk); while (!ovf_tick) @(negedge clk);
      check("R4 ovf spacing", cyc - t0, 11);
    end
    // R5: undoubled halves the rate
    setup(1, 0, 0, 0, 1, 8'hF5);
    expect_period("R5 sys1 F5h nodbl", 352, 3);
    // R2: quarter-rate system input
    setup(0, 1, 1, 0, 1, 8'hFE);
    expect_period("R2 sys4 FEh dbl", 128, 3);
    // R3: high-speed overrides quarter select
    setup(1, 1, 1, 0, 1, 8'hFE);
    expect_period("R3 override FEh", 32, 3);
    // R2: oscillator over 12, osc_en every 2 clocks
    setup(0, 0, 1, 0, 1, 8'hFF);
    expect_period("R2 osc12 FFh dbl", 384, 2);
    // R7: fixed path
    setup(0, 0, 1, 1, 1, 8'h10);
    expect_period("R7 fixed dbl", 64, 3);
    setup(1, 0, 0, 1, 1, 8'h10);
    expect_period("R7 fixed nodbl", 128, 3);
    setup(1, 1, 1, 1, 0, 8'hFF);
    expect_period("R7 fixed run off", 64, 2);

    // R8: stop, confirm silence, resume from held count
    setup(1, 0, 1, 0, 1, 8'h00);
    @(negedge clk); while (!ovf_tick) @(negedge clk);
    @(negedge clk); while (!ovf_tick) @(negedge clk);
    run = 1'b0;
    repeat (4) @(negedge clk);
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (ovf_tick || os_tick || bit_tick) seen++;
      end
      check("R8 silent while stopped", seen, 0);
    end
    run = 1'b1;
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!ovf_tick && n < 1000);
      check("R8 resume from held count", n, 256);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule